// File: doc/BRIEF.md
# Exception Entry Sequencer with Fixed Priority

This block sits beside a processor pipeline and turns pending exception and interrupt requests into the register-file writes that start a handler. Each cycle in which it is idle it looks at seven request lines (processor reset, undefined instruction, software interrupt, instruction-fetch abort, data abort, normal interrupt, fast interrupt). It drops the two interrupt lines when the matching mask bit is set in the current status word and picks one winner by fixed rank. It then snapshots the program counter and status word.

Over the next four cycles it emits, one per cycle and always in the same order, a write of the return address into the link register of the handler's mode, a write of the old status word into that mode's saved-status register, a write of the new status word, and a write of the vector address into the program counter. A one-cycle pipeline flush pulse accompanies the last write. The banked register file uses `bank_mode` to pick which copy of the link and saved-status registers to write.

The fast interrupt ranks above the normal interrupt. It can interrupt a running normal-interrupt handler, because normal-interrupt entry leaves the fast mask clear. Its vector occupies the last slot of the table, so its handler may be placed directly at that address.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after a clock edge that sampled it high, every write strobe and `flush` are low. `rst` abandons a sequence that is in progress.
- R2: Request bit positions are 0 reset, 1 undefined, 2 software interrupt, 3 fetch abort, 4 data abort, 5 normal interrupt, 6 fast interrupt. When several requests are eligible, the winner is the first eligible one in this order: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined, software interrupt.
- R3: The status-word fields are mode in bits 4:0, 16-bit state in bit 5, fast mask in bit 6 and normal mask in bit 7. A normal interrupt is ignored while bit 7 is 1, and a fast interrupt is ignored while bit 6 is 1. An ignored request produces no strobe.
- R4: After the clock edge that accepts a request, the block raises `lr_we`, `spsr_we`, `psr_we` and `pc_we` in four consecutive cycles in that order. Each strobe is high for exactly one cycle. `flush` is high only together with `pc_we`.
- R5: `bank_mode` gives the target mode for the whole sequence: 10011 for reset and software interrupt, 11011 for undefined, 10111 for either abort, 10010 for normal interrupt, 10001 for fast interrupt.
- R6: The vector written to the program counter is `VEC_BASE` plus one of these offsets: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C fetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt.
- R7: `cur_pc` is the address of the instruction at the exception point. The link value is `cur_pc`+8 for a data abort. It is `cur_pc`+2 for undefined and software interrupt when status bit 5 is set. In every other case it is `cur_pc`+4, so a normal-interrupt handler returns to the link value minus 4.
- R8: The saved-status data equals `cur_psr` as sampled at acceptance.
- R9: The new status word equals the sampled one with bits 4:0 set to the target mode, bit 5 cleared and bit 7 set. Bit 6 is set for fast interrupt and reset and otherwise kept. All bits above 7 are kept.
- R10: Requests and changes on `cur_pc`/`cur_psr` while a sequence is in progress have no effect on that sequence. A request that has gone away by the end of the sequence starts nothing.
- R11: A fast interrupt is taken when presented with the status word written by a normal-interrupt entry. After a fast-interrupt entry, both interrupt requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| exc_req | input | 7 | Exception request lines, bit positions per R2 |
| cur_pc | input | XLEN | Address of the instruction at the exception point |
| cur_psr | input | XLEN | Current status word |
| bank_mode | output | 5 | Mode selecting the banked link/saved-status copy |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | XLEN | Return address |
| spsr_we | output | 1 | Saved-status register write strobe |
| spsr_wdata | output | XLEN | Saved status word |
| psr_we | output | 1 | Status register write strobe |
| psr_wdata | output | XLEN | New status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | XLEN | Vector address |
| flush | output | 1 | One-cycle pipeline flush |

## Verification
Random request vectors, with each line set about one time in four, are combined with random status words. This drives the arbiter through many overlaps of eligible and masked requests, which separates a wrong rank from a wrong mask test. Directed pairs stand at each adjacent step of the ranking, including undefined against software interrupt and data abort against fast interrupt. Random 16-bit state and random program counters separate the link offsets of each exception kind. A chained normal-then-fast-then-both entry shows pre-emption and masking through the block's own status output. A burst of requests during a sequence shows that the snapshot is held.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_EXC = 7;
  localparam int MODE_W  = 5;
  localparam int PSR_I   = 7;
  localparam int PSR_F   = 6;
  localparam int PSR_T   = 5;

  typedef enum logic [2:0] {
    EX_RESET = 3'd0,
    EX_UNDEF = 3'd1,
    EX_SWI   = 3'd2,
    EX_PABT  = 3'd3,
    EX_DABT  = 3'd4,
    EX_IRQ   = 3'd5,
    EX_FIQ   = 3'd6
  } exc_e;

  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  // rank 0 is the strongest request
  function automatic exc_e prio_at(input int rank);
    case (rank)
      0:       prio_at = EX_RESET;
      1:       prio_at = EX_DABT;
      2:       prio_at = EX_FIQ;
      3:       prio_at = EX_IRQ;
      4:       prio_at = EX_PABT;
      5:       prio_at = EX_UNDEF;
      default: prio_at = EX_SWI;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input exc_e k);
    case (k)
      EX_UNDEF:        mode_of = M_UND;
      EX_PABT, EX_DABT: mode_of = M_ABT;
      EX_IRQ:          mode_of = M_IRQ;
      EX_FIQ:          mode_of = M_FIQ;
      default:         mode_of = M_SVC;
    endcase
  endfunction

  // table slot; slot 5 is left unused so the fast vector ends the table
  function automatic logic [2:0] slot_of(input exc_e k);
    case (k)
      EX_IRQ:  slot_of = 3'd6;
      EX_FIQ:  slot_of = 3'd7;
      default: slot_of = k;
    endcase
  endfunction

  function automatic logic [3:0] link_off(input exc_e k, input logic thumb);
    case (k)
      EX_DABT:        link_off = 4'd8;
      EX_UNDEF, EX_SWI: link_off = thumb ? 4'd2 : 4'd4;
      default:        link_off = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NUM_EXC-1:0] req,
  input  logic               irq_masked,
  input  logic               fiq_masked,
  output logic               any,
  output exc_e               win
);

  logic [NUM_EXC-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_EXC; g++) begin : g_mask
      if (g == int'(EX_IRQ)) begin : g_irq
        assign eligible[g] = req[g] & ~irq_masked;
      end else if (g == int'(EX_FIQ)) begin : g_fiq
        assign eligible[g] = req[g] & ~fiq_masked;
      end else begin : g_plain
        assign eligible[g] = req[g];
      end
    end
  endgenerate

  // scan from weakest to strongest so the strongest eligible one is left
  always_comb begin
    any = 1'b0;
    win = EX_RESET;
    for (int r = NUM_EXC - 1; r >= 0; r--) begin
      if (eligible[int'(prio_at(r))]) begin
        any = 1'b1;
        win = prio_at(r);
      end
    end
  end

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  exc_e              win,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   psr,
  output logic [MODE_W-1:0] mode,
  output logic [XLEN-1:0]   link,
  output logic [XLEN-1:0]   new_psr,
  output logic [XLEN-1:0]   vec
);

  always_comb begin
    mode = mode_of(win);
    link = pc + XLEN'(link_off(win, psr[PSR_T]));
    vec  = VEC_BASE + XLEN'({slot_of(win), 2'b00});
    new_psr               = psr;
    new_psr[MODE_W-1:0]   = mode;
    new_psr[PSR_T]        = 1'b0;
    new_psr[PSR_I]        = 1'b1;
    if (win == EX_FIQ || win == EX_RESET) new_psr[PSR_F] = 1'b1;
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [XLEN-1:0]   link_in,
  input  logic [XLEN-1:0]   spsr_in,
  input  logic [XLEN-1:0]   psr_in,
  input  logic [XLEN-1:0]   vec_in,
  output logic              busy,
  output logic [MODE_W-1:0] mode_q,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_q,
  output logic              spsr_we,
  output logic [XLEN-1:0]   spsr_q,
  output logic              psr_we,
  output logic [XLEN-1:0]   psr_q,
  output logic              pc_we,
  output logic [XLEN-1:0]   vec_q
);

  localparam int PH_N = 4;
  logic [PH_N-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (ph == '0) begin
      ph <= {{(PH_N-1){1'b0}}, start};
    end else begin
      ph <= ph << 1;
    end
  end

  // snapshot only when idle; data holds for the whole sequence
  always_ff @(posedge clk) begin
    if (ph == '0 && start) begin
      mode_q <= mode_in;
      lr_q   <= link_in;
      spsr_q <= spsr_in;
      psr_q  <= psr_in;
      vec_q  <= vec_in;
    end
  end

  assign busy    = |ph;
  assign lr_we   = ph[0];
  assign spsr_we = ph[1];
  assign psr_we  = ph[2];
  assign pc_we   = ph[3];

  AST_ONE_PHASE:  assert property (@(posedge clk) disable iff (rst) $onehot0({lr_we, spsr_we, psr_we, pc_we})); // R4
  AST_LR_SPSR:    assert property (@(posedge clk) disable iff (rst) lr_we |=> spsr_we); // R4
  AST_SPSR_PSR:   assert property (@(posedge clk) disable iff (rst) spsr_we |=> psr_we); // R4
  AST_PSR_PC:     assert property (@(posedge clk) disable iff (rst) psr_we |=> pc_we); // R4
  AST_HOLD_SNAP:  assert property (@(posedge clk) disable iff (rst) (busy && !pc_we) |=> ($stable(vec_q) && $stable(psr_q) && $stable(lr_q))); // R10

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXC-1:0]  exc_req,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     cur_psr,
  output logic [MODE_W-1:0]   bank_mode,
  output logic                lr_we,
  output logic [XLEN-1:0]     lr_wdata,
  output logic                spsr_we,
  output logic [XLEN-1:0]     spsr_wdata,
  output logic                psr_we,
  output logic [XLEN-1:0]     psr_wdata,
  output logic                pc_we,
  output logic [XLEN-1:0]     pc_wdata,
  output logic                flush
);

  logic              any_req;
  exc_e              win;
  logic [MODE_W-1:0] c_mode;
  logic [XLEN-1:0]   c_link, c_psr, c_vec;
  logic              busy;

  exc_arbiter u_arb (
    .req        (exc_req),
    .irq_masked (cur_psr[PSR_I]),
    .fiq_masked (cur_psr[PSR_F]),
    .any        (any_req),
    .win        (win)
  );

  exc_entry_calc #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_calc (
    .win     (win),
    .pc      (cur_pc),
    .psr     (cur_psr),
    .mode    (c_mode),
    .link    (c_link),
    .new_psr (c_psr),
    .vec     (c_vec)
  );

  exc_seq #(.XLEN(XLEN)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (any_req & ~busy),
    .mode_in (c_mode),
    .link_in (c_link),
    .spsr_in (cur_psr),
    .psr_in  (c_psr),
    .vec_in  (c_vec),
    .busy    (busy),
    .mode_q  (bank_mode),
    .lr_we   (lr_we),
    .lr_q    (lr_wdata),
    .spsr_we (spsr_we),
    .spsr_q  (spsr_wdata),
    .psr_we  (psr_we),
    .psr_q   (psr_wdata),
    .pc_we   (pc_we),
    .vec_q   (pc_wdata)
  );

  assign flush = pc_we;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) (lr_we && bank_mode == M_IRQ) |-> !$past(cur_psr[PSR_I])); // R3
  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (rst) (lr_we && bank_mode == M_FIQ) |-> !$past(cur_psr[PSR_F])); // R3
  AST_FIQ_WINS:   assert property (@(posedge clk) disable iff (rst) (lr_we && $past(exc_req[EX_FIQ] && exc_req[EX_IRQ] && !cur_psr[PSR_F] && !exc_req[EX_RESET] && !exc_req[EX_DABT])) |-> bank_mode == M_FIQ); // R2
  AST_VEC_RANGE:  assert property (@(posedge clk) disable iff (rst) pc_we |-> ((pc_wdata - VEC_BASE) <= XLEN'(28) && pc_wdata[1:0] == 2'b00)); // R6
  AST_NEW_MASKED: assert property (@(posedge clk) disable iff (rst) psr_we |-> (psr_wdata[PSR_I] && !psr_wdata[PSR_T])); // R9
  AST_FLUSH_ONCE: assert property (@(posedge clk) disable iff (rst) flush |=> !flush); // R4

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  exc_req;
  logic [31:0] cur_pc, cur_psr;
  logic [4:0]  bank_mode;
  logic        lr_we, spsr_we, psr_we, pc_we, flush;
  logic [31:0] lr_wdata, spsr_wdata, psr_wdata, pc_wdata;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .cur_pc(cur_pc), .cur_psr(cur_psr),
    .bank_mode(bank_mode), .lr_we(lr_we), .lr_wdata(lr_wdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .psr_we(psr_we), .psr_wdata(psr_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .flush(flush)
  );

  wire [4:0] stb = {lr_we, spsr_we, psr_we, pc_we, flush};

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  function automatic void chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endfunction

  // returns -1 when nothing is eligible
  function automatic int exp_win(input logic [6:0] r, input logic [31:0] p);
    logic [6:0] e;
    e = r;
    if (p[7]) e[5] = 1'b0;
    if (p[6]) e[6] = 1'b0;
    if (e[0]) return 0;
    if (e[4]) return 4;
    if (e[6]) return 6;
    if (e[5]) return 5;
    if (e[3]) return 3;
    if (e[1]) return 1;
    if (e[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] exp_mode(input int w);
    case (w)
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      5:       return 5'b10010;
      6:       return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int w);
    case (w)
      5:       return 32'h18;
      6:       return 32'h1C;
      default: return 32'(w * 4);
    endcase
  endfunction

  function automatic logic [31:0] exp_link(input int w, input logic [31:0] pc, input logic [31:0] p);
    if (w == 4) return pc + 32'd8;
    if ((w == 1 || w == 2) && p[5]) return pc + 32'd2;
    return pc + 32'd4;
  endfunction

  function automatic logic [31:0] exp_psr(input int w, input logic [31:0] p);
    logic [31:0] n;
    n = p;
    n[4:0] = exp_mode(w);
    n[5] = 1'b0;
    n[7] = 1'b1;
    if (w == 6 || w == 0) n[6] = 1'b1;
    return n;
  endfunction

  task automatic run_entry(input logic [6:0] r, input logic [31:0] pc, input logic [31:0] p,
                           input bit disturb, input string tag, output logic [31:0] new_p);
    int w;
    w = exp_win(r, p);
    new_p = p;
    @(negedge clk);
    exc_req = r; cur_pc = pc; cur_psr = p;
    @(negedge clk);
    exc_req = '0; cur_pc = $urandom; cur_psr = $urandom;
    if (w < 0) begin
      chk(stb == 5'b0, {tag, " R3 ignored request raised a strobe"}, 32'(stb), 32'h0);
      return;
    end
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk(stb == {k == 0, k == 1, k == 2, k == 3, k == 3}, {tag, " R4 strobe order"}, 32'(stb),
          32'({k == 0, k == 1, k == 2, k == 3, k == 3}));
      case (k)
        0: begin
          chk(bank_mode == exp_mode(w), {tag, " R5 R2 bank mode"}, 32'(bank_mode), 32'(exp_mode(w)));
          chk(lr_wdata == exp_link(w, pc, p), {tag, " R7 link value"}, lr_wdata, exp_link(w, pc, p));
        end
        1: chk(spsr_wdata == p, {tag, " R8 saved status"}, spsr_wdata, p);
        2: chk(psr_wdata == exp_psr(w, p), {tag, " R9 new status"}, psr_wdata, exp_psr(w, p));
        default: chk(pc_wdata == exp_vec(w), {tag, " R6 R2 vector"}, pc_wdata, exp_vec(w));
      endcase
      if (disturb && k == 1) exc_req = 7'h7F;
      if (disturb && k == 2) exc_req = '0;
    end
    @(negedge clk);
    chk(stb == 5'b0, {tag, " R4 R10 idle after sequence"}, 32'(stb), 32'h0);
    new_p = psr_wdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p1, p2, p3, pr;
    void'($urandom(32'd20240611));
    rst = 1'b1; exc_req = '0; cur_pc = '0; cur_psr = 32'h10;
    repeat (3) @(negedge clk);
    chk(stb == 5'b0, "R1 strobes during reset", 32'(stb), 32'h0);
    exc_req = 7'h7F;
    @(negedge clk);
    chk(stb == 5'b0, "R1 request held off by reset", 32'(stb), 32'h0);
    exc_req = '0;
    rst = 1'b0;
    @(negedge clk);
    chk(stb == 5'b0, "R1 idle after reset", 32'(stb), 32'h0);

    // ranking, one adjacent pair at a time
    run_entry(7'h7F, 32'h1000, 32'h10, 0, "R2 all", pr);
    run_entry(7'h70, 32'h1000, 32'h10, 0, "R2 dabt>fiq", pr);
    run_entry(7'h7E & ~7'h10, 32'h2000, 32'h10, 0, "R2 fiq>irq", pr);
    run_entry(7'h2E, 32'h2004, 32'h10, 0, "R2 irq>pabt", pr);
    run_entry(7'h0E, 32'h2008, 32'h10, 0, "R2 pabt>undef", pr);
    run_entry(7'h06, 32'h200C, 32'h30, 0, "R2 undef>swi thumb", pr);
    run_entry(7'h04, 32'h2010, 32'h30, 0, "R7 swi thumb", pr);
    run_entry(7'h04, 32'h2010, 32'h10, 0, "R7 swi word", pr);
    run_entry(7'h10, 32'h2014, 32'h30, 0, "R7 dabt thumb", pr);
    // masking
    run_entry(7'h20, 32'h3000, 32'h90, 0, "R3 irq masked", pr);
    run_entry(7'h40, 32'h3000, 32'h50, 0, "R3 fiq masked", pr);
    run_entry(7'h60, 32'h3000, 32'hD0, 0, "R3 both masked", pr);
    run_entry(7'h60, 32'h3000, 32'h50, 0, "R3 irq while fiq masked", pr);
    // pre-emption chain
    run_entry(7'h20, 32'h4000, 32'hF000_0010, 0, "R11 irq entry", p1);
    run_entry(7'h60, 32'h5000, p1, 0, "R11 fiq over irq handler", p2);
    chk(p2[4:0] == 5'b10001, "R11 fiq taken in irq handler", 32'(p2[4:0]), 32'h11);
    chk(p2[7] && p2[6], "R11 both masks set", 32'(p2[7:6]), 32'h3);
    run_entry(7'h60, 32'h6000, p2, 0, "R11 both ignored in fiq", p3);
    // disturbance during a sequence
    run_entry(7'h20, 32'h7000, 32'h1F, 1, "R10 disturbed", pr);
    // reset abandons a sequence
    @(negedge clk);
    exc_req = 7'h08; cur_psr = 32'h10;
    @(negedge clk);
    exc_req = '0; rst = 1'b1;
    @(negedge clk);
    chk(stb == 5'b0, "R1 sequence abandoned", 32'(stb), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(stb == 5'b0, "R1 nothing resumes", 32'(stb), 32'h0);

    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [6:0] r;
      logic [31:0] p;
      for (int b = 0; b < 7; b++) r[b] = ($urandom % 4) == 0;
      if ((t % 3) == 0) r[0] = 1'b0;
      if ((t % 2) == 0) r[4] = 1'b0;
      p = $urandom;
      p[4] = 1'b1;
      run_entry(r, $urandom, p, (t % 17) == 0, "R2 random", pr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule